// File: doc/BRIEF.md
# Unlock-Guarded Configuration Register

This block is a single byte-wide configuration and status register reached over a two-wire serial bus (I2C-style). The block acts as the target. It stores three pairs of persistent bits: a power-up delay selector, a block protection field and a pair of monitor-status flags. Two volatile enable latches sit in front of the persistent bits. A persistent update is accepted only after an arming write followed by an arming-plus-register write. Each accepted update starts a timed busy window that models a slow nonvolatile store.

A host writes to the block by addressing it as target 1010010, sending register pointer FFh and then one data byte. The byte takes effect at the STOP condition. A read uses a dummy write of the pointer, a repeated START with the read bit set, and one returned byte. A write-protect input blocks persistent commits. Each monitor flag is forced to zero while its monitor input is low. The stored fields also drive output pins, so neighbouring logic can use them directly.

Top module: `cfg_lock_reg`

## Requirements
- R1: The block acknowledges only the 7-bit target address 1010010. In a write it then acknowledges only the pointer byte FFh. Any other address or pointer is not acknowledged, and the rest of that transfer changes nothing.
- R2: A write of data 02h while RWEL is clear sets WEL. No busy window starts.
- R3: A write of data 06h while RWEL is clear sets both RWEL and WEL. RWEL is never set while WEL is clear.
- R4: With RWEL and WEL both set, a data byte with bit 2 = 0 and bit 1 = 1 commits at STOP. Bit 7 goes to por_sel[1] and bit 0 to por_sel[0]. Bits 4 and 3 go to blk_prot[1:0]. Bit 6 goes to the flag for monitor A and bit 5 to the flag for monitor B.
- R5: A commit clears RWEL, keeps WEL and holds busy_o high for BUSY_CYCLES clock cycles. During that window the target address is not acknowledged and the outputs keep their old values. The committed values appear when the window ends.
- R6: With RWEL and WEL both set, a data byte with bit 2 = 1 changes no stored field, starts no busy window and leaves RWEL set.
- R7: Only one data byte is taken per write. A second data byte is not acknowledged and cancels the whole write, so the latches and fields stay unchanged.
- R8: While wp_i is high, a commit byte changes no stored field and starts no busy window. It clears RWEL.
- R9: A read returns one byte laid out as {por_sel[1], flag A, flag B, blk_prot[1], blk_prot[0], RWEL, WEL, por_sel[0]}. Reads do not disturb the latches.
- R10: A monitor flag is zero in every cycle after one in which its monitor input is low. Reset clears both flags.
- R11: Any other data value leaves the stored fields unchanged and clears both latches. This covers a value other than 02h or 06h without RWEL, and a byte with RWEL set whose bit 2 = 0 and bit 1 = 0.
- R12: After reset, every stored field and latch reads zero and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus lines are oversampled on it |
| rst_n | input | 1 | Active-low reset, models power-up |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_o | output | 1 | High pulls the data line low (open drain) |
| wp_i | input | 1 | Write protect; high blocks persistent commits |
| mon_a_ok_i | input | 1 | Monitor A output; low clears flag A |
| mon_b_ok_i | input | 1 | Monitor B output; low clears flag B |
| por_sel_o | output | 2 | Stored power-up delay selector |
| blk_prot_o | output | 2 | Stored block protection field |
| mon_flag_o | output | 2 | Stored monitor flags, [1] = A, [0] = B |
| busy_o | output | 1 | Persistent store in progress |

## Verification
The assertions check invariants on every cycle. RWEL never stands without WEL. A busy window starts only on a commit. The address is never acknowledged while busy. A write-protected commit or a sentinel byte leaves the persistent outputs still. The monitor flags fall one cycle after a low monitor input. The target only moves the data line while the clock is low. The bench scenarios cover the sequences: the three-step unlock, the byte layout of a commit and of a read, a cancelled two-byte write, rejected addresses and pointers, clearing writes, and the length of the busy window. These can only be shown by comparing readback over whole transfers.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  localparam logic [6:0] TGT_ADDR = 7'b1010010;
  localparam logic [7:0] PTR_REG  = 8'hFF;
  localparam logic [7:0] ARM_WEL  = 8'h02;
  localparam logic [7:0] ARM_BOTH = 8'h06;

  typedef enum logic [2:0] {
    ACT_SET_WEL,
    ACT_SET_BOTH,
    ACT_REARM,
    ACT_COMMIT,
    ACT_BLOCKED,
    ACT_CLEAR
  } cfg_act_e;

  typedef enum logic [2:0] {
    BS_IDLE, BS_RX, BS_ACK, BS_TX, BS_TXACK, BS_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA} bus_ph_e;

  // Decide what a single accepted data byte does to the latches.
  function automatic cfg_act_e cfg_classify(input logic [7:0] b,
                                            input logic wel, input logic rwel,
                                            input logic wp);
    cfg_act_e a;
    if (wel && rwel) begin
      if (b[2])      a = ACT_REARM;
      else if (b[1]) a = wp ? ACT_BLOCKED : ACT_COMMIT;
      else           a = ACT_CLEAR;
    end else if (b == ARM_WEL)  a = ACT_SET_WEL;
    else if (b == ARM_BOTH)     a = ACT_SET_BOTH;
    else                        a = ACT_CLEAR;
    return a;
  endfunction

  // Read-back layout of the register.
  function automatic logic [7:0] cfg_pack(input logic [1:0] por,
                                          input logic [1:0] flag,
                                          input logic [1:0] bp,
                                          input logic rwel, input logic wel);
    return {por[1], flag[1], flag[0], bp[1], bp[0], rwel, wel, por[0]};
  endfunction

endpackage

// File: rtl/cfg_lock_bus.sv
module cfg_lock_bus
  import cfg_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       busy_i,
  input  logic [7:0] rd_byte_i,
  output logic       sda_pull_o,
  output logic       scl_lvl_o,
  output logic       wr_evt_o,
  output logic [7:0] wr_byte_o,
  output logic       addr_ack_evt_o
);

  logic [2:0] scl_q, sda_q;
  logic       scl_s, scl_p, sda_s, sda_p;
  logic       rise, fall, start_c, stop_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s   = scl_q[1];
  assign scl_p   = scl_q[2];
  assign sda_s   = sda_q[1];
  assign sda_p   = sda_q[2];
  assign rise    = scl_s & ~scl_p;
  assign fall    = ~scl_s & scl_p;
  assign start_c = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_lvl_o = scl_s;

  bus_st_e    st;
  bus_ph_e    ph;
  logic [7:0] sh, tx, data_q;
  logic [3:0] cnt;
  logic       rd, have_data, drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= BS_IDLE; ph <= PH_ADDR; sh <= '0; tx <= '0; data_q <= '0;
      cnt <= '0; rd <= 1'b0; have_data <= 1'b0; drv <= 1'b0;
      wr_evt_o <= 1'b0; addr_ack_evt_o <= 1'b0;
    end else begin
      wr_evt_o       <= 1'b0;
      addr_ack_evt_o <= 1'b0;
      if (start_c) begin
        st <= BS_RX; ph <= PH_ADDR; cnt <= '0; have_data <= 1'b0; drv <= 1'b0;
      end else if (stop_c) begin
        wr_evt_o  <= have_data;
        have_data <= 1'b0;
        st        <= BS_IDLE;
        drv       <= 1'b0;
      end else begin
        unique case (st)
          BS_RX: begin
            if (rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              unique case (ph)
                PH_ADDR: begin
                  if (sh[7:1] == TGT_ADDR && !busy_i) begin
                    drv <= 1'b1; st <= BS_ACK; rd <= sh[0];
                    addr_ack_evt_o <= 1'b1;
                  end else st <= BS_SKIP;
                end
                PH_PTR: begin
                  if (sh == PTR_REG) begin drv <= 1'b1; st <= BS_ACK; end
                  else st <= BS_SKIP;
                end
                default: begin
                  if (!have_data) begin
                    data_q <= sh; have_data <= 1'b1; drv <= 1'b1; st <= BS_ACK;
                  end else begin
                    have_data <= 1'b0; st <= BS_SKIP;
                  end
                end
              endcase
            end
          end
          BS_ACK: begin
            if (fall) begin
              if (ph == PH_ADDR && rd) begin
                tx  <= rd_byte_i;
                drv <= ~rd_byte_i[7];
                cnt <= 4'd1;
                st  <= BS_TX;
              end else begin
                drv <= 1'b0;
                cnt <= '0;
                st  <= BS_RX;
                ph  <= (ph == PH_ADDR) ? PH_PTR : PH_DATA;
              end
            end
          end
          BS_TX: begin
            if (fall) begin
              if (cnt == 4'd8) begin
                drv <= 1'b0; st <= BS_TXACK;
              end else begin
                tx  <= {tx[6:0], 1'b0};
                drv <= ~tx[6];
                cnt <= cnt + 4'd1;
              end
            end
          end
          BS_TXACK: if (rise) st <= BS_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = drv;
  assign wr_byte_o  = data_q;

endmodule

// File: rtl/cfg_lock_core.sv
module cfg_lock_core
  import cfg_lock_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_evt_i,
  input  logic [7:0] wr_byte_i,
  input  logic       wp_i,
  input  logic       mon_a_ok_i,
  input  logic       mon_b_ok_i,
  output logic [7:0] rd_byte_o,
  output logic [1:0] por_sel_o,
  output logic [1:0] blk_prot_o,
  output logic [1:0] mon_flag_o,
  output logic       busy_o,
  output logic       wel_o,
  output logic       rwel_o,
  output logic       commit_evt_o,
  output logic       rearm_evt_o
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYCLES);

  cfg_act_e    act;
  logic        wel, rwel, expire;
  logic [CW-1:0] busy_cnt;
  logic [1:0]  por, bp, flag, p_por, p_bp, p_flag, flag_base;

  assign act          = cfg_classify(wr_byte_i, wel, rwel, wp_i);
  assign commit_evt_o = wr_evt_i && act == ACT_COMMIT;
  assign rearm_evt_o  = wr_evt_i && act == ACT_REARM;
  assign expire       = busy_cnt == CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; rwel <= 1'b0;
    end else if (wr_evt_i) begin
      unique case (act)
        ACT_SET_WEL:  wel <= 1'b1;
        ACT_SET_BOTH: begin wel <= 1'b1; rwel <= 1'b1; end
        ACT_REARM:    rwel <= 1'b1;
        ACT_COMMIT,
        ACT_BLOCKED:  rwel <= 1'b0;
        default:      begin wel <= 1'b0; rwel <= 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0; p_por <= '0; p_bp <= '0; p_flag <= '0;
    end else if (commit_evt_o) begin
      busy_cnt <= BUSY_LOAD;
      p_por    <= {wr_byte_i[7], wr_byte_i[0]};
      p_bp     <= wr_byte_i[4:3];
      p_flag   <= wr_byte_i[6:5];
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por <= '0; bp <= '0;
    end else if (expire) begin
      por <= p_por; bp <= p_bp;
    end
  end

  // A low monitor input overrides everything else on its flag.
  assign flag_base = expire ? p_flag : flag;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= flag_base & {mon_a_ok_i, mon_b_ok_i};
  end

  assign rd_byte_o  = cfg_pack(por, flag, bp, rwel, wel);
  assign por_sel_o  = por;
  assign blk_prot_o = bp;
  assign mon_flag_o = flag;
  assign busy_o     = busy_cnt != '0;
  assign wel_o      = wel;
  assign rwel_o     = rwel;

endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg #(
  parameter int unsigned BUSY_CYCLES = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       wp_i,
  input  logic       mon_a_ok_i,
  input  logic       mon_b_ok_i,
  output logic [1:0] por_sel_o,
  output logic [1:0] blk_prot_o,
  output logic [1:0] mon_flag_o,
  output logic       busy_o
);

  logic       wr_evt, addr_ack_evt, scl_lvl;
  logic       wel, rwel, commit_evt, rearm_evt;
  logic [7:0] wr_byte, rd_byte;

  cfg_lock_bus u_bus (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl_i),
    .sda_i          (sda_i),
    .busy_i         (busy_o),
    .rd_byte_i      (rd_byte),
    .sda_pull_o     (sda_pull_o),
    .scl_lvl_o      (scl_lvl),
    .wr_evt_o       (wr_evt),
    .wr_byte_o      (wr_byte),
    .addr_ack_evt_o (addr_ack_evt)
  );

  cfg_lock_core #(.BUSY_CYCLES(BUSY_CYCLES)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_evt_i     (wr_evt),
    .wr_byte_i    (wr_byte),
    .wp_i         (wp_i),
    .mon_a_ok_i   (mon_a_ok_i),
    .mon_b_ok_i   (mon_b_ok_i),
    .rd_byte_o    (rd_byte),
    .por_sel_o    (por_sel_o),
    .blk_prot_o   (blk_prot_o),
    .mon_flag_o   (mon_flag_o),
    .busy_o       (busy_o),
    .wel_o        (wel),
    .rwel_o       (rwel),
    .commit_evt_o (commit_evt),
    .rearm_evt_o  (rearm_evt)
  );

endmodule

// File: rtl/cfg_lock_chk.sv
module cfg_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_i,
  input logic       mon_a_ok_i,
  input logic       mon_b_ok_i,
  input logic       sda_pull_o,
  input logic       scl_lvl,
  input logic       busy_o,
  input logic [1:0] por_sel_o,
  input logic [1:0] blk_prot_o,
  input logic [1:0] mon_flag_o,
  input logic       wel,
  input logic       rwel,
  input logic       wr_evt,
  input logic       commit_evt,
  input logic       rearm_evt,
  input logic       addr_ack_evt
);

  assert_rwel_has_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);

  assert_busy_from_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(commit_evt));

  assert_no_ack_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack_evt |-> !$past(busy_o));

  assert_sentinel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_evt |=> rwel && $stable(por_sel_o) && $stable(blk_prot_o) && !busy_o);

  assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && wp_i |=> $stable(por_sel_o) && $stable(blk_prot_o) && !$rose(busy_o));

  assert_flag_a_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_a_ok_i |=> !mon_flag_o[1]);

  assert_flag_b_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_b_ok_i |=> !mon_flag_o[0]);

  assert_sda_low_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_lvl);

endmodule

bind cfg_lock_reg cfg_lock_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wp_i         (wp_i),
  .mon_a_ok_i   (mon_a_ok_i),
  .mon_b_ok_i   (mon_b_ok_i),
  .sda_pull_o   (sda_pull_o),
  .scl_lvl      (scl_lvl),
  .busy_o       (busy_o),
  .por_sel_o    (por_sel_o),
  .blk_prot_o   (blk_prot_o),
  .mon_flag_o   (mon_flag_o),
  .wel          (wel),
  .rwel         (rwel),
  .wr_evt       (wr_evt),
  .commit_evt   (commit_evt),
  .rearm_evt    (rearm_evt),
  .addr_ack_evt (addr_ack_evt)
);

// File: tb/test_cfg_lock_reg.sv
`timescale 1ns/1ps
module test_cfg_lock_reg;

  localparam int BUSY = 300;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic wp = 1'b0, mon_a = 1'b1, mon_b = 1'b1;
  logic sda_pull, busy;
  logic [1:0] por_sel, blk_prot, mon_flag;
  logic sda_line;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  cfg_lock_reg #(.BUSY_CYCLES(BUSY)) i_cfg_lock_reg (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .wp_i(wp), .mon_a_ok_i(mon_a), .mon_b_ok_i(mon_b),
    .por_sel_o(por_sel), .blk_prot_o(blk_prot), .mon_flag_o(mon_flag),
    .busy_o(busy)
  );

  // scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [7:0] sb_e, sb_a;
  string sb_t;

  always @(negedge clk) begin
    if (exp_q.size() > 0 && act_q.size() > 0) begin
      sb_e = exp_q.pop_front();
      sb_a = act_q.pop_front();
      sb_t = tag_q.pop_front();
      vectors++;
      if (sb_a !== sb_e) begin
        miscompares++;
        $display("FAIL %s: actual %02h expected %02h", sb_t, sb_a, sb_e);
      end
    end
  end

  task automatic expect_val(input string t, input logic [7:0] e, input logic [7:0] a);
    tag_q.push_back(t);
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  // expected read byte, assembled from named fields
  function automatic logic [7:0] rb(input bit q, x, y, s, t, rw, w, r);
    logic [7:0] v;
    v = '0;
    v[0] = r; v[1] = w; v[2] = rw; v[3] = t; v[4] = s; v[5] = y; v[6] = x; v[7] = q;
    return v;
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
    end
    wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic reg_wr(input logic [7:0] d, output logic ack_d);
    logic a0, a1;
    bus_start(); send(8'hA4, a0); send(8'hFF, a1); send(d, ack_d); bus_stop();
    wq();
  endtask

  task automatic reg_rd(output logic [7:0] d);
    logic a0, a1, a2;
    bus_start(); send(8'hA4, a0); send(8'hFF, a1);
    bus_start(); send(8'hA5, a2); recv(d); bus_stop();
    wq();
  endtask

  task automatic wait_busy();
    repeat (BUSY + 50) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a, b;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R12 reset state
    expect_val("R12 outputs", 8'h00, {1'b0, busy, por_sel, blk_prot, mon_flag});
    reg_rd(d); expect_val("R12 read", 8'h00, d);

    // R1 wrong target address and wrong pointer
    bus_start(); send(8'hA6, a); bus_stop(); wq();
    expect_val("R1 foreign address ack", 8'h00, {7'd0, a});
    bus_start(); send(8'hA4, a); send(8'h00, b); send(8'h02, a); bus_stop(); wq();
    expect_val("R1 bad pointer ack", 8'h00, {7'd0, b});
    reg_rd(d); expect_val("R1 nothing changed", 8'h00, d);

    // R2 arm WEL
    reg_wr(8'h02, a);
    expect_val("R2 busy stays low", 8'h00, {7'd0, busy});
    reg_rd(d); expect_val("R2 WEL set", rb(0,0,0,0,0,0,1,0), d);

    // R3 arm both, R9 repeated reads keep latches
    reg_wr(8'h06, a);
    reg_rd(d); expect_val("R3 both latches", rb(0,0,0,0,0,1,1,0), d);
    reg_rd(d); expect_val("R9 read keeps latches", rb(0,0,0,0,0,1,1,0), d);

    // R4 / R5 commit 1101_0011
    reg_wr(8'hD3, a);
    expect_val("R5 busy high", 8'h01, {7'd0, busy});
    expect_val("R5 outputs held while busy", 8'h00, {4'd0, por_sel, blk_prot});
    bus_start(); send(8'hA5, a); bus_stop(); wq();
    expect_val("R5 address nacked while busy", 8'h00, {7'd0, a});
    wait_busy();
    expect_val("R5 busy ended", 8'h00, {7'd0, busy});
    expect_val("R4 por_sel", 8'h03, {6'd0, por_sel});
    expect_val("R4 blk_prot", 8'h02, {6'd0, blk_prot});
    expect_val("R4 mon_flag", 8'h02, {6'd0, mon_flag});
    reg_rd(d); expect_val("R4 R5 readback RWEL clear", rb(1,1,0,1,0,0,1,1), d);

    // R6 sentinel re-arm
    reg_wr(8'h06, a);
    reg_wr(8'h26, a);
    expect_val("R6 no busy", 8'h00, {7'd0, busy});
    reg_rd(d); expect_val("R6 fields kept RWEL set", rb(1,1,0,1,0,1,1,1), d);

    // R7 two data bytes
    bus_start(); send(8'hA4, a); send(8'hFF, a);
    send(8'h02, a); send(8'h02, b); bus_stop(); wq();
    expect_val("R7 first byte acked", 8'h01, {7'd0, a});
    expect_val("R7 second byte nacked", 8'h00, {7'd0, b});
    expect_val("R7 no busy", 8'h00, {7'd0, busy});
    reg_rd(d); expect_val("R7 nothing committed", rb(1,1,0,1,0,1,1,1), d);

    // R8 write protect
    wp = 1'b1;
    reg_wr(8'h02, a);
    expect_val("R8 no busy", 8'h00, {7'd0, busy});
    wp = 1'b0;
    reg_rd(d); expect_val("R8 fields kept RWEL cleared", rb(1,1,0,1,0,0,1,1), d);

    // R11 clearing writes
    reg_wr(8'h55, a);
    reg_rd(d); expect_val("R11 wrong unlock clears latches", rb(1,1,0,1,0,0,0,1), d);
    reg_wr(8'h0A, a);
    expect_val("R11 no busy", 8'h00, {7'd0, busy});
    reg_rd(d); expect_val("R11 commit without RWEL ignored", rb(1,1,0,1,0,0,0,1), d);

    // R10 monitor A low clears flag A
    mon_a = 1'b0; repeat (4) @(negedge clk);
    expect_val("R10 flag A cleared", 8'h00, {6'd0, mon_flag});
    mon_a = 1'b1;
    reg_rd(d); expect_val("R10 readback", rb(1,0,0,1,0,0,0,1), d);

    // R4 three-step sequence committing all zero
    reg_wr(8'h02, a); reg_wr(8'h06, a); reg_wr(8'h02, a);
    wait_busy();
    expect_val("R4 zero commit outputs", 8'h00, {2'd0, por_sel, blk_prot, mon_flag});
    reg_rd(d); expect_val("R4 zero commit read", rb(0,0,0,0,0,0,1,0), d);

    // R10 flags set, then cleared by reset
    reg_wr(8'h06, a); reg_wr(8'h62, a);
    wait_busy();
    expect_val("R10 both flags set", 8'h03, {6'd0, mon_flag});
    reg_rd(d); expect_val("R10 readback flags", rb(0,1,1,0,0,0,1,0), d);
    rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    expect_val("R10 R12 reset clears flags", 8'h00, {1'b0, busy, por_sel, blk_prot, mon_flag});
    reg_rd(d); expect_val("R12 read after reset", 8'h00, d);

    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule